// File: doc/BRIEF.md
# Serial Flash Command Decoder

This block is the slave-side command front end of a three-wire serial flash. It samples chip select, serial clock and serial data with the system clock and finds rising and falling serial clock edges. Leading zeros are skipped until a start bit appears. It then assembles the command byte and any argument and security bytes that follow. Decoded commands become single-cycle strobes: address loads and increments go to an external address register, bit steps go to an external page shift register, and array operation requests go to an external timing model. That model answers with a done/ok pulse.

The decoder tracks three things: a busy flag for the running array operation, a write-enable latch, and a pass flag for the last write or erase. Destructive commands are refused unless the security byte 0x55 arrives and the latch is set. When the block is selected and not shifting out status or data, the serial output shows a ready/busy level. When deselected, the output enable is low. A rising chip select abandons any partly received command. An array operation that has already been requested still runs to completion.

Top module: `sflash_cmd_dec`

## Requirements
- R1: While idle, zeros sampled on rising serial clock edges are skipped; the first 1 sampled is bit 7 of a command byte, and further bits are taken MSB first.
- R2: A command byte has bits 6:3 as opcode and bits 2:0 zero. A byte with nonzero bits 2:0, or with an opcode outside the defined set, is discarded. All further input is then ignored until chip select rises. Command bytes: status 0x80, set-address 0x88, increment 0x90, read 0x98, write 0xA0, erase 0xA8, shift-in 0xB0, shift-out 0xB8, read-last 0xD0, enable 0xE0, disable 0xE8, write-last 0xF0.
- R3: Status is accepted even while busy. It returns bit 7 = ready, bit 6 = pass, bit 5 = write enabled and bit 0 = large variant; bits 4:1 are 0. The bits are presented MSB first, each changing on a falling serial clock edge, starting with the falling edge of the command's last bit.
- R4: With chip select low and no status or data being shifted, sdo_o is 1 when ready and 0 when busy. sdo_oe_o is 0 while chip select is high.
- R5: The write-enable latch is clear after reset. Enable (0xE0) sets it and disable (0xE8) clears it, and both are accepted while busy.
- R6: Write (0xA0) and write-last (0xF0) start an operation only when the next byte is 0x55 and the latch is set. The op_kind_o codes are 1 for write and 4 for write-last.
- R7: Erase (0xA8) takes a block byte and then 0x55. It needs the latch, and it is refused when the block equals LAST_BLK. op_kind_o is 2 and op_blk_o carries the block.
- R8: Read (0x98) and read-last (0xD0) need no latch and use op_kind_o 0 and 3. Any command that would start an operation or shift data while busy starts nothing.
- R9: Set-address takes a block byte and then a page byte, and gives one addr_load_o pulse carrying both. Increment gives one addr_inc_o pulse.
- R10: Shift-in with argument N gives N+1 sh_step_o pulses, each on a rising edge. Each pulse carries the sampled data bit on sh_bit_o.
- R11: Shift-out with argument N presents N+1 bits of sh_dout_i on sdo_o, each on a falling edge. Each bit is recirculated through sh_step_o/sh_bit_o.
- R12: op_req_o sets busy until op_done_i. Completion of a write, write-last or erase stores op_ok_i as the pass flag. Reads and discarded commands leave the pass flag unchanged.
- R13: A rising chip select returns the decoder to start-bit search, while a requested operation still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out / ready-busy level |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| addr_load_o | output | 1 | Address load strobe |
| addr_blk_o | output | 8 | Block byte for address load |
| addr_page_o | output | 8 | Page byte for address load |
| addr_inc_o | output | 1 | Address increment strobe |
| sh_step_o | output | 1 | Page shift register step strobe |
| sh_bit_o | output | 1 | Bit shifted into page register |
| sh_dout_i | input | 1 | Page shift register MSB |
| op_req_o | output | 1 | Array operation request pulse |
| op_kind_o | output | 3 | Operation code (see R6-R8) |
| op_blk_o | output | 8 | Erase block |
| op_done_i | input | 1 | Array operation complete pulse |
| op_ok_i | input | 1 | Result of completed operation |

## Verification
On every cycle, the assertions check three rules for each operation request: it only starts when idle, a destructive kind only starts with the latch set, and an erase never targets the last block. They also check that busy only rises after a request, and that step strobes only come from the shift states. The bench scenarios are the only way to show the byte-level decoding. That covers start-bit skipping, rejection of bad reserved bits, bad opcodes and bad security bytes, and the contents and timing of the status byte. It also covers the shift-in/shift-out round trip through an external register model, the pass flag across good and failed completions, and abort by chip select during a command and during a running operation.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    K_READ   = 3'd0,
    K_WRITE  = 3'd1,
    K_ERASE  = 3'd2,
    K_RDLAST = 3'd3,
    K_WRLAST = 3'd4
  } op_kind_e;

  typedef enum logic [3:0] {
    OC_STAT    = 4'h0,
    OC_SETADDR = 4'h1,
    OC_INC     = 4'h2,
    OC_READ    = 4'h3,
    OC_WRITE   = 4'h4,
    OC_ERASE   = 4'h5,
    OC_SHIN    = 4'h6,
    OC_SHOUT   = 4'h7,
    OC_RDLAST  = 4'hA,
    OC_WEN     = 4'hC,
    OC_WDIS    = 4'hD,
    OC_WRLAST  = 4'hE
  } opc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ARG1, S_ARG2, S_SEC, S_SHIN, S_SHOUT, S_STAT, S_SKIP
  } st_e;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SEC_CODE = 8'h55;
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int N        = 3,
  parameter int STAGES   = 2,
  parameter int EDGE_IDX = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic         rise_o,
  output logic         fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RST_VAL[g]}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end

  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL[EDGE_IDX];
    else         prev_q <= q_o[EDGE_IDX];
  end
  assign rise_o =  q_o[EDGE_IDX] & ~prev_q;
  assign fall_o = ~q_o[EDGE_IDX] &  prev_q;
endmodule

// File: rtl/sfc_opctl.sv
module sfc_opctl import sfc_pkg::*; #(
  parameter logic [7:0] LAST_BLK = 8'd127
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] kind_i,
  input  logic [7:0] blk_i,
  input  logic       wen_set_i,
  input  logic       wen_clr_i,
  input  logic       done_i,
  input  logic       ok_i,
  output logic       busy_o,
  output logic       wen_o,
  output logic       pass_o
);
  logic     busy_q, wen_q, pass_q;
  op_kind_e run_q;
  logic     run_destr;

  assign run_destr = (run_q == K_WRITE) || (run_q == K_WRLAST) || (run_q == K_ERASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wen_q  <= 1'b0;
      pass_q <= 1'b0;
      run_q  <= K_READ;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        run_q  <= op_kind_e'(kind_i);
      end else if (done_i && busy_q) begin
        busy_q <= 1'b0;
        if (run_destr) pass_q <= ok_i;
      end
      if (wen_set_i)      wen_q <= 1'b1;
      else if (wen_clr_i) wen_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign wen_o  = wen_q;
  assign pass_o = pass_q;

  a_r8_no_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  a_r6_wen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (kind_i == K_WRITE || kind_i == K_WRLAST || kind_i == K_ERASE) |-> wen_q);
  a_r7_erase_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && kind_i == K_ERASE |-> blk_i != LAST_BLK);
  a_r12_busy_from_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
endmodule

// File: rtl/sfc_sdo.sv
module sfc_sdo #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          busy_i,
  input  logic          drive_i,
  input  logic          stat_load_i,
  input  logic [BW-1:0] stat_byte_i,
  input  logic          pres_stat_i,
  input  logic          pres_data_i,
  input  logic          data_bit_i,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  logic [BW-1:0] stat_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      out_q  <= 1'b1;
    end else begin
      if (stat_load_i) stat_q <= stat_byte_i;
      else if (pres_stat_i) begin
        out_q  <= stat_q[BW-1];
        stat_q <= {stat_q[BW-2:0], 1'b0};
      end else if (pres_data_i) out_q <= data_bit_i;
    end
  end

  assign sdo_o    = drive_i ? out_q : ~busy_i;
  assign sdo_oe_o = cs_act_i;
endmodule

// File: rtl/sfc_fsm.sv
module sfc_fsm import sfc_pkg::*; #(
  parameter logic [7:0] LAST_BLK = 8'd127,
  parameter bit         LARGE    = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_act_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       sdi_i,
  input  logic       busy_i,
  input  logic       wen_i,
  input  logic       pass_i,
  input  logic       sh_dout_i,
  output logic       start_o,
  output logic [2:0] kind_o,
  output logic [7:0] blk_o,
  output logic       wen_set_o,
  output logic       wen_clr_o,
  output logic       addr_load_o,
  output logic [7:0] addr_blk_o,
  output logic [7:0] addr_page_o,
  output logic       addr_inc_o,
  output logic       sh_step_o,
  output logic       sh_bit_o,
  output logic       stat_load_o,
  output logic [7:0] stat_byte_o,
  output logic       pres_stat_o,
  output logic       pres_data_o,
  output logic       drive_o
);
  st_e       state_q;
  opc_e      opc_q;
  op_kind_e  kind_q;
  logic [2:0] bcnt_q;
  logic [6:0] rx_q;
  logic [7:0] arg_q, cnt_q, blk_q, ablk_q, apage_q;
  logic       fin_q, start_q, wset_q, wclr_q, aload_q, ainc_q, step_q, bit_q;

  logic [7:0] byte_w;
  opc_e       opc_w;
  logic       recv, byte_done, sec_ok;

  assign byte_w    = {rx_q, sdi_i};
  assign opc_w     = opc_e'(byte_w[6:3]);
  assign recv      = (state_q == S_CMD) || (state_q == S_ARG1) ||
                     (state_q == S_ARG2) || (state_q == S_SEC);
  assign byte_done = cs_act_i && rise_i && recv && (bcnt_q == 3'd7);
  assign sec_ok    = (byte_w == SEC_CODE) && wen_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      opc_q   <= OC_STAT;
      kind_q  <= K_READ;
      bcnt_q  <= '0;
      rx_q    <= '0;
      arg_q   <= '0;
      cnt_q   <= '0;
      blk_q   <= '0;
      ablk_q  <= '0;
      apage_q <= '0;
      fin_q   <= 1'b0;
      start_q <= 1'b0;
      wset_q  <= 1'b0;
      wclr_q  <= 1'b0;
      aload_q <= 1'b0;
      ainc_q  <= 1'b0;
      step_q  <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      wset_q  <= 1'b0;
      wclr_q  <= 1'b0;
      aload_q <= 1'b0;
      ainc_q  <= 1'b0;
      step_q  <= 1'b0;
      if (!cs_act_i) begin
        state_q <= S_IDLE;
        bcnt_q  <= '0;
        fin_q   <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE: if (rise_i && sdi_i) begin
            state_q <= S_CMD;
            rx_q    <= 7'd1;
            bcnt_q  <= 3'd1;
          end
          S_CMD, S_ARG1, S_ARG2, S_SEC: if (rise_i) begin
            rx_q   <= {rx_q[5:0], sdi_i};
            bcnt_q <= bcnt_q + 3'd1;
            if (bcnt_q == 3'd7) begin
              bcnt_q <= '0;
              if (state_q == S_CMD) begin
                opc_q <= opc_w;
                if (byte_w[2:0] != 3'b000) state_q <= S_SKIP;
                else begin
                  case (opc_w)
                    OC_STAT: begin
                      state_q <= S_STAT;
                      cnt_q   <= 8'd7;
                      fin_q   <= 1'b0;
                    end
                    OC_SETADDR, OC_ERASE: state_q <= S_ARG1;
                    OC_SHIN, OC_SHOUT:    state_q <= busy_i ? S_SKIP : S_ARG1;
                    OC_WRITE, OC_WRLAST:  state_q <= S_SEC;
                    OC_INC: begin
                      ainc_q  <= 1'b1;
                      state_q <= S_IDLE;
                    end
                    OC_READ, OC_RDLAST: begin
                      state_q <= S_IDLE;
                      if (!busy_i) begin
                        start_q <= 1'b1;
                        kind_q  <= (opc_w == OC_READ) ? K_READ : K_RDLAST;
                        blk_q   <= '0;
                      end
                    end
                    OC_WEN: begin
                      wset_q  <= 1'b1;
                      state_q <= S_IDLE;
                    end
                    OC_WDIS: begin
                      wclr_q  <= 1'b1;
                      state_q <= S_IDLE;
                    end
                    default: state_q <= S_SKIP;
                  endcase
                end
              end else if (state_q == S_ARG1) begin
                arg_q <= byte_w;
                case (opc_q)
                  OC_SETADDR: state_q <= S_ARG2;
                  OC_ERASE:   state_q <= S_SEC;
                  OC_SHIN: begin
                    cnt_q   <= byte_w;
                    state_q <= S_SHIN;
                  end
                  OC_SHOUT: begin
                    cnt_q   <= byte_w;
                    fin_q   <= 1'b0;
                    state_q <= S_SHOUT;
                  end
                  default: state_q <= S_SKIP;
                endcase
              end else if (state_q == S_ARG2) begin
                aload_q <= 1'b1;
                ablk_q  <= arg_q;
                apage_q <= byte_w;
                state_q <= S_IDLE;
              end else begin
                state_q <= S_IDLE;
                if (sec_ok) begin
                  if (opc_q == OC_ERASE) begin
                    if (arg_q != LAST_BLK) begin
                      start_q <= 1'b1;
                      kind_q  <= K_ERASE;
                      blk_q   <= arg_q;
                    end
                  end else begin
                    start_q <= 1'b1;
                    kind_q  <= (opc_q == OC_WRITE) ? K_WRITE : K_WRLAST;
                    blk_q   <= '0;
                  end
                end
              end
            end
          end
          S_SHIN: if (rise_i) begin
            step_q <= 1'b1;
            bit_q  <= sdi_i;
            if (cnt_q == 8'd0) state_q <= S_IDLE;
            else               cnt_q   <= cnt_q - 8'd1;
          end
          S_SHOUT: if (fall_i) begin
            if (fin_q) state_q <= S_IDLE;
            else begin
              step_q <= 1'b1;
              bit_q  <= sh_dout_i;
              if (cnt_q == 8'd0) fin_q <= 1'b1;
              else               cnt_q <= cnt_q - 8'd1;
            end
          end
          S_STAT: if (fall_i) begin
            if (fin_q)              state_q <= S_IDLE;
            else if (cnt_q == 8'd0) fin_q   <= 1'b1;
            else                    cnt_q   <= cnt_q - 8'd1;
          end
          S_SKIP: ;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign stat_load_o = byte_done && (state_q == S_CMD) &&
                       (byte_w[2:0] == 3'b000) && (opc_w == OC_STAT);
  assign stat_byte_o = {~busy_i, pass_i, wen_i, 4'b0000, LARGE};
  assign pres_stat_o = cs_act_i && fall_i && (state_q == S_STAT)  && !fin_q;
  assign pres_data_o = cs_act_i && fall_i && (state_q == S_SHOUT) && !fin_q;
  assign drive_o     = (state_q == S_STAT) || (state_q == S_SHOUT);

  assign start_o     = start_q;
  assign kind_o      = kind_q;
  assign blk_o       = blk_q;
  assign wen_set_o   = wset_q;
  assign wen_clr_o   = wclr_q;
  assign addr_load_o = aload_q;
  assign addr_blk_o  = ablk_q;
  assign addr_page_o = apage_q;
  assign addr_inc_o  = ainc_q;
  assign sh_step_o   = step_q;
  assign sh_bit_o    = bit_q;

  a_r10_step_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |-> $past(state_q == S_SHIN || state_q == S_SHOUT));
  a_r2_skip_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_SKIP |-> !start_q && !wset_q && !wclr_q && !aload_q);
endmodule

// File: rtl/sflash_cmd_dec.sv
module sflash_cmd_dec #(
  parameter logic [7:0] LAST_BLK = 8'd127,
  parameter bit         LARGE    = 1'b0,
  parameter int         SYNC_N   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  output logic       addr_load_o,
  output logic [7:0] addr_blk_o,
  output logic [7:0] addr_page_o,
  output logic       addr_inc_o,
  output logic       sh_step_o,
  output logic       sh_bit_o,
  input  logic       sh_dout_i,
  output logic       op_req_o,
  output logic [2:0] op_kind_o,
  output logic [7:0] op_blk_o,
  input  logic       op_done_i,
  input  logic       op_ok_i
);
  logic [2:0] pins_q;
  logic       rise, fall;
  logic       busy, wen, pass, start, wset, wclr;
  logic       stat_load, pres_stat, pres_data, drive;
  logic [7:0] stat_byte;

  // bit 0 chip-select active, bit 1 serial clock, bit 2 serial data
  sfc_sync #(.N(3), .STAGES(SYNC_N), .EDGE_IDX(1), .RST_VAL(3'b000)) u_sync (
    .clk_i, .rst_ni,
    .d_i    ({sdi_i, sck_i, ~cs_ni}),
    .q_o    (pins_q),
    .rise_o (rise),
    .fall_o (fall)
  );

  sfc_fsm #(.LAST_BLK(LAST_BLK), .LARGE(LARGE)) u_fsm (
    .clk_i, .rst_ni,
    .cs_act_i    (pins_q[0]),
    .rise_i      (rise),
    .fall_i      (fall),
    .sdi_i       (pins_q[2]),
    .busy_i      (busy),
    .wen_i       (wen),
    .pass_i      (pass),
    .sh_dout_i   (sh_dout_i),
    .start_o     (start),
    .kind_o      (op_kind_o),
    .blk_o       (op_blk_o),
    .wen_set_o   (wset),
    .wen_clr_o   (wclr),
    .addr_load_o (addr_load_o),
    .addr_blk_o  (addr_blk_o),
    .addr_page_o (addr_page_o),
    .addr_inc_o  (addr_inc_o),
    .sh_step_o   (sh_step_o),
    .sh_bit_o    (sh_bit_o),
    .stat_load_o (stat_load),
    .stat_byte_o (stat_byte),
    .pres_stat_o (pres_stat),
    .pres_data_o (pres_data),
    .drive_o     (drive)
  );

  sfc_opctl #(.LAST_BLK(LAST_BLK)) u_opctl (
    .clk_i, .rst_ni,
    .start_i   (start),
    .kind_i    (op_kind_o),
    .blk_i     (op_blk_o),
    .wen_set_i (wset),
    .wen_clr_i (wclr),
    .done_i    (op_done_i),
    .ok_i      (op_ok_i),
    .busy_o    (busy),
    .wen_o     (wen),
    .pass_o    (pass)
  );

  sfc_sdo #(.BW(8)) u_sdo (
    .clk_i, .rst_ni,
    .cs_act_i    (pins_q[0]),
    .busy_i      (busy),
    .drive_i     (drive),
    .stat_load_i (stat_load),
    .stat_byte_i (stat_byte),
    .pres_stat_i (pres_stat),
    .pres_data_i (pres_data),
    .data_bit_i  (sh_dout_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  assign op_req_o = start;
endmodule

// File: tb/tb_sflash_cmd_dec.sv
module tb_sflash_cmd_dec;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int WD    = 150000;

  logic clk = 0, rst_n = 0;
  logic cs_ni = 1, sck = 0, sdi = 0;
  logic sdo, sdo_oe, addr_load, addr_inc, sh_step, sh_bit, op_req;
  logic [7:0] addr_blk, addr_page, op_blk;
  logic [2:0] op_kind;
  logic op_done = 0, op_ok = 1;
  logic [15:0] dreg = '0;
  logic ok_val = 1;
  int   op_lat = 20;
  int   checks = 0, fails = 0, steps = 0;
  int   exp_code[$];
  string exp_req[$];

  always #(CLK_P/2) clk = ~clk;

  sflash_cmd_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .addr_load_o(addr_load), .addr_blk_o(addr_blk),
    .addr_page_o(addr_page), .addr_inc_o(addr_inc), .sh_step_o(sh_step),
    .sh_bit_o(sh_bit), .sh_dout_i(dreg[15]), .op_req_o(op_req), .op_kind_o(op_kind),
    .op_blk_o(op_blk), .op_done_i(op_done), .op_ok_i(op_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int code(int t, int k, int b, int p);
    return (t << 24) | (k << 16) | (b << 8) | p;
  endfunction

  task automatic expect_ev(input int c, input string req);
    exp_code.push_back(c);
    exp_req.push_back(req);
  endtask

  task automatic got(input int c);
    if (exp_code.size() == 0) chk(1'b0, "R8 unexpected event", c, 0);
    else begin
      int e = exp_code.pop_front();
      string r = exp_req.pop_front();
      chk(e == c, r, c, e);
    end
  endtask

  // scoreboard monitor and page register model
  always @(negedge clk) if (rst_n) begin
    if (op_req)    got(code(1, int'(op_kind), int'(op_blk), 0));
    if (addr_load) got(code(2, 0, int'(addr_blk), int'(addr_page)));
    if (addr_inc)  got(code(3, 0, 0, 0));
    if (sh_step) begin
      dreg = {dreg[14:0], sh_bit};
      steps++;
    end
  end

  // array timing model
  always begin
    @(negedge clk);
    if (op_req) begin
      repeat (op_lat) @(negedge clk);
      op_ok = ok_val;
      op_done = 1;
      @(negedge clk);
      op_done = 0;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic rd);
    sdi = b;
    wait_clk(HALF);
    rd = sdo;
    sck = 1;
    wait_clk(HALF);
    sck = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic rd;
    for (int i = 7; i >= 0; i--) pulse(v[i], rd);
    sdi = 0;
  endtask

  task automatic read_bits(input int n, output logic [15:0] v);
    logic rd;
    v = '0;
    for (int i = 0; i < n; i++) begin
      pulse(1'b0, rd);
      v = {v[14:0], rd};
    end
  endtask

  task automatic status(input logic [7:0] exp, input string req);
    logic [15:0] v;
    send_byte(8'h80);
    read_bits(8, v);
    chk(v[7:0] == exp, req, int'(v[7:0]), int'(exp));
  endtask

  task automatic reselect();
    cs_ni = 1;
    wait_clk(10);
    cs_ni = 0;
    wait_clk(10);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic rd;
    logic [15:0] v;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    chk(sdo_oe == 0, "R4 deselected oe", sdo_oe, 0);
    cs_ni = 0;
    wait_clk(10);
    chk(sdo_oe == 1 && sdo == 1, "R4 ready level", {sdo_oe, sdo}, 3);

    // R1 leading zeros, R3 format, R5 power-up disabled
    for (int i = 0; i < 3; i++) pulse(1'b0, rd);
    status(8'h80, "R1 R3 R5 status after zeros");

    // R6 write refused without latch, R12 pass untouched
    send_byte(8'hA0); send_byte(8'h55);
    status(8'h80, "R6 R12 write without enable");

    send_byte(8'hE0);
    status(8'hA0, "R5 enable sets latch");

    // R9
    expect_ev(code(2, 0, 8'h12, 8'h34), "R9 address load");
    send_byte(8'h88); send_byte(8'h12); send_byte(8'h34);
    expect_ev(code(3, 0, 0, 0), "R9 increment");
    send_byte(8'h90);

    // R6 bad security byte then good write
    send_byte(8'hA0); send_byte(8'h54);
    expect_ev(code(1, 1, 0, 0), "R6 write request");
    ok_val = 1;
    send_byte(8'hA0); send_byte(8'h55);
    wait_clk(60);
    status(8'hE0, "R12 write passed");

    // R7 last block refused, normal erase with failure
    send_byte(8'hA8); send_byte(8'd127); send_byte(8'h55);
    status(8'hE0, "R7 R12 last-block erase refused");
    ok_val = 0;
    expect_ev(code(1, 2, 5, 0), "R7 erase request");
    send_byte(8'hA8); send_byte(8'h05); send_byte(8'h55);
    wait_clk(60);
    status(8'hA0, "R12 erase failed");

    // R8 reads, R6 write-last
    ok_val = 1;
    expect_ev(code(1, 0, 0, 0), "R8 read request");
    send_byte(8'h98); wait_clk(60);
    expect_ev(code(1, 3, 0, 0), "R8 read-last request");
    send_byte(8'hD0); wait_clk(60);
    status(8'hA0, "R12 reads keep pass");
    expect_ev(code(1, 4, 0, 0), "R6 write-last request");
    send_byte(8'hF0); send_byte(8'h55); wait_clk(60);

    // busy window
    op_lat = 2000;
    expect_ev(code(1, 0, 0, 0), "R8 long read");
    send_byte(8'h98);
    status(8'h60, "R3 status while busy");
    send_byte(8'hE8);
    send_byte(8'hA0); send_byte(8'h55);
    send_byte(8'h98);
    wait_clk(10);
    chk(sdo == 0, "R4 busy level", sdo, 0);
    wait_clk(2000);
    chk(sdo == 1, "R4 ready after done", sdo, 1);
    status(8'hC0, "R5 disable while busy");

    // R2 bad reserved bits / bad opcode
    send_byte(8'h81); send_byte(8'hE0);
    reselect();
    send_byte(8'hC0); send_byte(8'hE0);
    reselect();
    status(8'hC0, "R2 discarded commands");

    // R13 operation runs on after deselect
    op_lat = 1500;
    expect_ev(code(1, 0, 0, 0), "R13 read request");
    send_byte(8'h98);
    cs_ni = 1;
    wait_clk(10);
    chk(sdo_oe == 0, "R4 R13 deselected during op", sdo_oe, 0);
    wait_clk(1600);
    cs_ni = 0;
    wait_clk(10);
    chk(sdo == 1, "R13 op completed", sdo, 1);
    op_lat = 20;

    // R13 partial command abandoned
    send_byte(8'hE0);
    send_byte(8'hA8);
    reselect();
    status(8'hE0, "R13 aborted erase then status");

    // R10 shift-in
    steps = 0;
    send_byte(8'hB0); send_byte(8'h0F);
    send_byte(8'hA5); send_byte(8'hC3);
    wait_clk(10);
    chk(steps == 16, "R10 step count", steps, 16);
    chk(dreg == 16'hA5C3, "R10 shifted data", dreg, 16'hA5C3);

    // R11 shift-out
    steps = 0;
    send_byte(8'hB8); send_byte(8'h0F);
    read_bits(16, v);
    wait_clk(10);
    chk(v == 16'hA5C3, "R11 data out", v, 16'hA5C3);
    chk(dreg == 16'hA5C3 && steps == 16, "R11 recirculated", dreg, 16'hA5C3);
    chk(sdo == 1, "R4 ready after shift-out", sdo, 1);

    wait_clk(100);
    chk(exp_code.size() == 0, "R12 all expected requests seen", exp_code.size(), 0);
    finish_run();
  end
endmodule